// File: doc/BRIEF.md
# Servo Update Timer with Synchronized Outputs

This block sets the rate of a servo control loop. A free-running down-counter, reloaded from a host-supplied period value, expires once per servo period. Each expiry is an update event. In that event the block does three things at once. It emits a capture strobe that freezes every encoder counter at the same instant. It copies the host's pending velocity commands for all axes into the registers that drive the DAC or step-rate outputs. It raises a sticky interrupt, so the real-time task runs right after the hardware has sampled and updated. Because every step follows from one hardware edge, no software timing jitter enters the loop.

The host loads the next velocity commands into shadow registers at any time during the period. The active outputs change only on an update event. The host can also request an update by software. This produces the same strobe, command transfer and interrupt as a timer expiry, and it is the only way to get updates while the timer is disabled. If an event arrives while the interrupt is still pending, an overrun flag records that the host has fallen behind.

Typical periods run from about 1 ms down to 50 µs (loop rates of 1 kHz to 20 kHz). The period is expressed in system clock ticks.

Top module: `servo_sync_timer`

## Requirements
- R1: During reset and on the first cycle after it, `capture_o`, `irq_o` and `overrun_o` are 0, and every active command is 0.
- R2: While `tmr_en` is 1, timer events repeat every `reload_i`+1 clock cycles. The counter takes a new `reload_i` only when it reloads, which happens on expiry or while the timer is disabled. A changed period therefore applies from the next reload.
- R3: `capture_o` is high for exactly one cycle per update event. It is never high in two consecutive cycles. A request (timer or software) made in a cycle where `capture_o` is high is dropped.
- R4: All active commands take their shadow values in the same cycle that `capture_o` is high, and at no other time.
- R5: When `cmd_wr_en` is 1, `cmd_wr_data` is written to the shadow register selected by `cmd_wr_axis`. Axis k occupies `active_cmd_o[16k+15:16k]`. A write made in the same cycle as an update event is not part of that update; it goes out on the next event.
- R6: While `tmr_en` is 0, the timer produces no events. A `sw_trig` pulse still produces a full update.
- R7: `irq_o` goes to 1 with each strobe and holds until a cycle with `irq_clr` = 1. If an event and `irq_clr` fall in the same cycle, `irq_o` stays 1.
- R8: `overrun_o` goes to 1 when an event occurs while `irq_o` is 1 and `irq_clr` is 0. It holds until `ovr_clr` = 1. If a new overrun and `ovr_clr` fall in the same cycle, the new overrun wins.
- R9: A software trigger yields the same update as a timer expiry. A software request and a timer expiry in the same cycle yield a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_en | input | 1 | Timer enable |
| reload_i | input | 16 | Period reload value in clock ticks (interval = value + 1) |
| sw_trig | input | 1 | Software update request, one cycle per request |
| cmd_wr_en | input | 1 | Shadow command write strobe |
| cmd_wr_axis | input | 2 | Axis selected for the shadow write |
| cmd_wr_data | input | 16 | Velocity command value to write |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| capture_o | output | 1 | One-cycle encoder capture strobe |
| active_cmd_o | output | 64 | Active velocity commands, axis k in bits 16k+15:16k |
| irq_o | output | 1 | Sticky update interrupt |
| overrun_o | output | 1 | Sticky missed-acknowledge flag |

## Verification
Assertions check several properties on every cycle:
- the strobe never lasts two cycles;
- the active commands never move outside a strobe cycle;
- the interrupt is always high alongside the strobe;
- neither sticky flag drops without its clear;
- overrun rises only if the interrupt was already pending;
- no strobe appears without a timer enable or a software request in the prior cycle.

Only the bench scenarios can show the following: the exact interval of `reload_i`+1 cycles; when a changed period takes effect; that the right shadow values reach each axis; that a write in the event cycle waits for the next event; and how coincident or back-to-back requests merge.

// File: rtl/sst_pkg.sv
// Package sst_pkg
// Shared defaults and helper functions for the servo update timer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration rules.
package sst_pkg;

    localparam int SST_AXES_DEF   = 4;   // number of servo axes
    localparam int SST_CMD_W_DEF  = 16;  // velocity command width
    localparam int SST_PER_W_DEF  = 16;  // period reload width

    // Width of an index that selects one of n items (at least one bit).
    function automatic int sst_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sst_period_timer.sv
// Module sst_period_timer
// Down-counter that expires once every reload+1 cycles while enabled.
// It reloads from reload_i on expiry, and continuously while disabled, so
// a new period applies from the next reload. hit_o is combinational and
// is high in the cycle the enabled counter sits at zero.
// Assumes: reload_i is quasi-static (driven from a host register).
module sst_period_timer #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic [PERIOD_W-1:0] reload_i,
    output logic                hit_o
);

    logic [PERIOD_W-1:0] cnt_q;
    logic                at_zero;

    assign at_zero = (cnt_q == '0);
    assign hit_o   = en_i && at_zero;

    // Count down while enabled; reload on expiry or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || at_zero) begin
            cnt_q <= reload_i;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/sst_cmd_bank.sv
// Module sst_cmd_bank
// Double-buffered velocity command storage, one shadow/active pair per
// axis. Host writes land in the shadow. A load pulse copies every shadow
// into its active register in one edge, taking the shadow value held
// before that edge.
// Assumes: load_i is at most one cycle per event.
module sst_cmd_bank #(
    parameter int NUM_AXES = 4,
    parameter int CMD_W    = 16,
    parameter int AXIS_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [AXIS_W-1:0]         wr_axis_i,
    input  logic [CMD_W-1:0]          wr_data_i,
    input  logic                      load_i,
    output logic [NUM_AXES*CMD_W-1:0] active_o
);

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        logic [CMD_W-1:0] shadow_q;
        logic [CMD_W-1:0] active_q;
        logic             sel;

        assign sel = wr_en_i && (wr_axis_i == AXIS_W'(a));

        // Capture host writes addressed to this axis.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (sel) begin
                shadow_q <= wr_data_i;
            end
        end

        // Transfer the pending command on an update event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (load_i) begin
                active_q <= shadow_q;
            end
        end

        assign active_o[a*CMD_W +: CMD_W] = active_q;
    end

endmodule

// File: rtl/sst_irq_ctrl.sv
// Module sst_irq_ctrl
// Sticky interrupt and overrun flags. An event sets the interrupt. An
// event that finds the interrupt still pending, and not being cleared in
// that cycle, sets overrun. In a conflict with a clear, the set wins.
// Assumes: clears are write-one pulses from the host.
module sst_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic irq_clr_i,
    input  logic ovr_clr_i,
    output logic irq_o,
    output logic ovr_o
);

    logic irq_q;
    logic ovr_q;
    logic missed;

    assign missed = event_i && irq_q && !irq_clr_i;

    // Interrupt flag: set by event, cleared by host, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (event_i) begin
            irq_q <= 1'b1;
        end else if (irq_clr_i) begin
            irq_q <= 1'b0;
        end
    end

    // Overrun flag: set on an unacknowledged repeat event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (missed) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr_i) begin
            ovr_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;
    assign ovr_o = ovr_q;

    // R7: the interrupt only drops after a host clear
    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(irq_clr_i));

    // R8: overrun only drops after its clear
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_o) |-> $past(ovr_clr_i));

    // R8: overrun only rises while an interrupt was pending
    a_r8_ovr_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_o) |-> $past(irq_o));

endmodule

// File: rtl/servo_sync_timer.sv
// Module servo_sync_timer (top)
// Servo loop update timer. A timer expiry or a software request forms an
// update event. The event is registered into a one-cycle capture strobe,
// the command transfer for all axes, and the interrupt, all at one edge.
// Requests made while the strobe is high are dropped, so strobes never
// touch.
// Assumes: synchronous inputs in the clk domain.
module servo_sync_timer
    import sst_pkg::*;
#(
    parameter int  NUM_AXES = SST_AXES_DEF,
    parameter int  CMD_W    = SST_CMD_W_DEF,
    parameter int  PERIOD_W = SST_PER_W_DEF,
    localparam int AXIS_W   = sst_idx_w(NUM_AXES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tmr_en,
    input  logic [PERIOD_W-1:0]       reload_i,
    input  logic                      sw_trig,
    input  logic                      cmd_wr_en,
    input  logic [AXIS_W-1:0]         cmd_wr_axis,
    input  logic [CMD_W-1:0]          cmd_wr_data,
    input  logic                      irq_clr,
    input  logic                      ovr_clr,
    output logic                      capture_o,
    output logic [NUM_AXES*CMD_W-1:0] active_cmd_o,
    output logic                      irq_o,
    output logic                      overrun_o
);

    logic tmr_hit;
    logic update_ev;
    logic capture_q;

    sst_period_timer #(
        .PERIOD_W (PERIOD_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tmr_en),
        .reload_i (reload_i),
        .hit_o    (tmr_hit)
    );

    // Merge timer and software requests; suppress during a strobe.
    assign update_ev = (tmr_hit || sw_trig) && !capture_q;

    // Register the event into the one-cycle capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            capture_q <= 1'b0;
        end else begin
            capture_q <= update_ev;
        end
    end

    assign capture_o = capture_q;

    sst_cmd_bank #(
        .NUM_AXES (NUM_AXES),
        .CMD_W    (CMD_W),
        .AXIS_W   (AXIS_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (cmd_wr_en),
        .wr_axis_i (cmd_wr_axis),
        .wr_data_i (cmd_wr_data),
        .load_i    (update_ev),
        .active_o  (active_cmd_o)
    );

    sst_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_i   (update_ev),
        .irq_clr_i (irq_clr),
        .ovr_clr_i (ovr_clr),
        .irq_o     (irq_o),
        .ovr_o     (overrun_o)
    );

    // R3: the capture strobe is never high two cycles running
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |=> !capture_o);

    // R4: active commands move only together with the strobe
    a_r4_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_o |-> $stable(active_cmd_o));

    // R7: every strobe is accompanied by a pending interrupt
    a_r7_irq_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> irq_o);

    // R6: no strobe without an enabled timer or a software request
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tmr_en) && !$past(sw_trig)) |-> !capture_o);

endmodule

// File: tb/sim_servo_sync_timer.sv
module sim_servo_sync_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tmr_en;
    logic [15:0] reload_i;
    logic        sw_trig;
    logic        cmd_wr_en;
    logic [1:0]  cmd_wr_axis;
    logic [15:0] cmd_wr_data;
    logic        irq_clr;
    logic        ovr_clr;
    logic        capture_o;
    logic [63:0] active_cmd_o;
    logic        irq_o;
    logic        overrun_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    servo_sync_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_en       (tmr_en),
        .reload_i     (reload_i),
        .sw_trig      (sw_trig),
        .cmd_wr_en    (cmd_wr_en),
        .cmd_wr_axis  (cmd_wr_axis),
        .cmd_wr_data  (cmd_wr_data),
        .irq_clr      (irq_clr),
        .ovr_clr      (ovr_clr),
        .capture_o    (capture_o),
        .active_cmd_o (active_cmd_o),
        .irq_o        (irq_o),
        .overrun_o    (overrun_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int axis_cmd(input int a);
        return int'(active_cmd_o[a*16 +: 16]);
    endfunction

    // Behavioural reference: ticks left, pending flags, command lists
    int m_left;
    int m_cap, m_irq, m_ovr;
    int m_shadow[NA];
    int m_active[NA];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_left <= 0; m_cap <= 0; m_irq <= 0; m_ovr <= 0;
            for (int a = 0; a < NA; a++) begin
                m_shadow[a] <= 0; m_active[a] <= 0;
            end
        end else begin
            int go;
            go = ((tmr_en && m_left == 0) || sw_trig) && (m_cap == 0) ? 1 : 0;
            if (!tmr_en || m_left == 0) m_left <= int'(reload_i);
            else                        m_left <= m_left - 1;
            m_cap <= go;
            if (go) for (int a = 0; a < NA; a++) m_active[a] <= m_shadow[a];
            if (cmd_wr_en) m_shadow[cmd_wr_axis] <= int'(cmd_wr_data);
            if (go) m_irq <= 1; else if (irq_clr) m_irq <= 0;
            if (go && m_irq && !irq_clr) m_ovr <= 1; else if (ovr_clr) m_ovr <= 0;
        end
    end

    // Compare against the reference away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R3 capture strobe", int'(capture_o), m_cap);
            chk("R7 irq flag", int'(irq_o), m_irq);
            chk("R8 overrun flag", int'(overrun_o), m_ovr);
            for (int a = 0; a < NA; a++) chk("R4 active cmd", axis_cmd(a), m_active[a]);
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic pulse_trig;
        sw_trig = 1'b1; tick(); sw_trig = 1'b0;
    endtask

    task automatic clear_flags;
        irq_clr = 1'b1; ovr_clr = 1'b1; tick(); irq_clr = 1'b0; ovr_clr = 1'b0; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        int caps;
        int ev_at[4];
        rst_n = 0; tmr_en = 0; reload_i = 16'd9; sw_trig = 0;
        cmd_wr_en = 0; cmd_wr_axis = '0; cmd_wr_data = '0; irq_clr = 0; ovr_clr = 0;
        repeat (3) tick();
        // R1: reset state
        chk("R1 capture", int'(capture_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 overrun", int'(overrun_o), 0);
        chk("R1 active", int'(active_cmd_o != '0), 0);
        rst_n = 1; tick();
        chk("R1 capture after release", int'(capture_o), 0);

        // R5: shadow writes do not reach the outputs by themselves
        for (int a = 0; a < NA; a++) begin
            cmd_wr_en = 1; cmd_wr_axis = 2'(a); cmd_wr_data = 16'(100 + a*7); tick();
        end
        cmd_wr_en = 0; tick();
        chk("R5 no transfer without event", axis_cmd(0), 0);

        // R6 / R9: software update with timer disabled
        pulse_trig();
        chk("R6 sw trig while disabled", int'(capture_o), 1);
        for (int a = 0; a < NA; a++) chk("R9 sw update value", axis_cmd(a), 100 + a*7);
        chk("R7 irq set", int'(irq_o), 1);
        tick();
        chk("R3 strobe one cycle", int'(capture_o), 0);

        // R8: second event with irq pending
        pulse_trig();
        chk("R8 overrun set", int'(overrun_o), 1);
        clear_flags();
        chk("R7 irq cleared", int'(irq_o), 0);
        chk("R8 overrun cleared", int'(overrun_o), 0);

        // R7: set beats clear; acknowledged event is no overrun
        pulse_trig(); tick();
        sw_trig = 1; irq_clr = 1; tick(); sw_trig = 0; irq_clr = 0;
        chk("R7 set wins over clear", int'(irq_o), 1);
        chk("R8 no overrun when acknowledged", int'(overrun_o), 0);
        tick();
        // R8: new overrun beats ovr_clr
        sw_trig = 1; ovr_clr = 1; tick(); sw_trig = 0; ovr_clr = 0;
        chk("R8 set wins over clear", int'(overrun_o), 1);
        clear_flags();

        // R3: back-to-back requests give one strobe
        caps = 0;
        sw_trig = 1; tick(); caps += int'(capture_o);
        tick(); caps += int'(capture_o); sw_trig = 0;
        tick(); caps += int'(capture_o);
        chk("R3 dropped request during strobe", caps, 1);

        // R5: write on the event cycle waits for the next event
        cmd_wr_en = 1; cmd_wr_axis = 2'd2; cmd_wr_data = 16'd300; tick();
        cmd_wr_data = 16'd555; sw_trig = 1; tick(); cmd_wr_en = 0; sw_trig = 0;
        chk("R5 same-cycle write excluded", axis_cmd(2), 300);
        tick();
        pulse_trig();
        chk("R5 write applied next event", axis_cmd(2), 555);
        clear_flags();

        // R2: interval reload+1 with reload 9
        reload_i = 16'd9; tmr_en = 1;
        caps = 0;
        for (int i = 0; i < 200 && caps < 4; i++) begin
            tick();
            if (capture_o) begin ev_at[caps] = cyc; caps++; end
        end
        chk("R2 events seen", caps, 4);
        chk("R2 interval 10", ev_at[2] - ev_at[1], 10);
        chk("R2 interval 10 repeat", ev_at[3] - ev_at[2], 10);

        // R2: period change applies from next reload
        reload_i = 16'd4;
        caps = 0;
        for (int i = 0; i < 200 && caps < 3; i++) begin
            tick();
            if (capture_o) begin ev_at[caps] = cyc; caps++; end
        end
        chk("R2 new interval 5", ev_at[2] - ev_at[1], 5);

        // R6: disabled timer stays silent
        tmr_en = 0; tick(); tick();
        caps = 0;
        for (int i = 0; i < 40; i++) begin tick(); caps += int'(capture_o); end
        chk("R6 no timer events when disabled", caps, 0);
        clear_flags();

        // R9 / R3: software requests held high alongside the timer
        tmr_en = 1; reload_i = 16'd3; sw_trig = 1;
        caps = 0;
        for (int i = 0; i < 20; i++) begin tick(); caps += int'(capture_o); end
        sw_trig = 0;
        chk("R9 merged requests alternate", caps, 10);
        tmr_en = 0;
        repeat (5) tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule